// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps an asynchronous DRAM alive by issuing one row refresh at a time, spaced evenly over the retention interval. A free-running timer sets the refresh rate. Each time the timer expires, the block raises a bus request to the access arbiter. Once the bus is granted, it drives the row strobe and the column strobe through one refresh cycle. It then releases the bus after the precharge time has been met.

A build parameter picks one of two strobe styles:

- **Row-address-only refresh.** The block's own row counter supplies the address. The address is held on the bus while the row strobe is low, and the column strobe stays idle.
- **Column-before-row refresh.** The column strobe falls first, which is the reverse of an ordinary access. No address is driven, and the device steps its own internal row counter.

If a timer expiry arrives while a refresh is still waiting for the bus, the block records it in a saturating counter of missed refreshes.

Top module: `refresh_scheduler`

## Requirements
- R1: While reset is held, rasN and casN are 1, busReq and addrEn are 0 and missCount is 0.
- R2: The refresh timer runs freely with a period of TIMER_PERIOD clock cycles. With busGrant held at 1, consecutive falling edges of rasN are exactly TIMER_PERIOD cycles apart.
- R3: A timer expiry raises busReq, and busReq stays at 1 until the refresh cycle ends. No strobe moves while busGrant is 0. When busGrant is sampled at 1 with a refresh pending, rasN falls in the second following cycle in row-address-only mode.
- R4: In row-address-only mode (CBR_MODE=0), addrEn is 1 for LEAD_CYC cycles before rasN falls and for as long as rasN stays low, and casN stays at 1 at all times.
- R5: In column-before-row mode (CBR_MODE=1), casN goes low LEAD_CYC cycles before rasN falls. casN stays low while rasN is low and rises together with it. addrEn stays 0 at all times.
- R6: During a refresh, rasN is low for exactly RAS_LOW_CYC cycles.
- R7: After rasN rises, it stays high for PRECHARGE_CYC cycles with busReq still at 1, and busReq drops after that.
- R8: Refreshes use rowAddr values 0, 1, ..., NUM_ROWS-1 in order, then wrap back to 0. The first refresh after reset uses row 0.
- R9: A timer expiry while a refresh is still pending, and not completing in that same cycle, adds one to missCount. missCount saturates at its all-ones value and never moves by more than one per cycle. When busGrant is always 1, missCount stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busGrant | input | 1 | Arbiter grant; held at 1 while busReq is 1 and the grant has been given |
| busReq | output | 1 | Request for the DRAM bus; 1 while a refresh is pending or in progress |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| addrEn | output | 1 | 1 when rowAddr is to be driven onto the DRAM address pins |
| rowAddr | output | $clog2(NUM_ROWS) | Row index of the current or next refresh |
| missCount | output | MISS_W | Saturating count of timer expiries lost while a refresh was pending |

## Verification
The grant-ordering property assumes the arbiter never drops busGrant in the middle of a refresh. The bench honours this by changing busGrant only at negative clock edges, and only while busReq is 0 or no cycle has started. The strobe-width and row-order properties assume the refresh cycle length (LEAD_CYC + RAS_LOW_CYC + PRECHARGE_CYC) is shorter than TIMER_PERIOD. The bench parameter set keeps this with a wide margin. Starved-grant windows are started just after a cycle ends, so the number of expiries inside each window is known in advance.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_STROBE,
    ST_PRECH
  } rfshState_t;

  // strobes from the control sequencer to the datapath
  typedef struct packed {
    logic rasLow;
    logic casLow;
    logic addrEn;
    logic cycleDone;
  } rfshStrobe_t;

endpackage

// File: rtl/refresh_ctrl.sv
module refresh_ctrl
  import refresh_pkg::*;
#(
  parameter int CBR_MODE      = 0,
  parameter int LEAD_CYC      = 1,
  parameter int RAS_LOW_CYC   = 3,
  parameter int PRECHARGE_CYC = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pending,
  input  logic        busGrant,
  output rfshStrobe_t strobe
);

  localparam int MAX_PHASE = (LEAD_CYC > RAS_LOW_CYC)
                             ? ((LEAD_CYC > PRECHARGE_CYC) ? LEAD_CYC : PRECHARGE_CYC)
                             : ((RAS_LOW_CYC > PRECHARGE_CYC) ? RAS_LOW_CYC : PRECHARGE_CYC);
  localparam int CNT_W = $clog2(MAX_PHASE + 1);

  rfshState_t state;
  logic [CNT_W-1:0] phaseCnt;
  logic leadEnd, strobeEnd, prechEnd;

  assign leadEnd   = (phaseCnt == CNT_W'(LEAD_CYC - 1));
  assign strobeEnd = (phaseCnt == CNT_W'(RAS_LOW_CYC - 1));
  assign prechEnd  = (phaseCnt == CNT_W'(PRECHARGE_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          phaseCnt <= '0;
          if (pending && busGrant) state <= ST_LEAD;
        end
        ST_LEAD: begin
          if (leadEnd) begin
            state    <= ST_STROBE;
            phaseCnt <= '0;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        ST_STROBE: begin
          if (strobeEnd) begin
            state    <= ST_PRECH;
            phaseCnt <= '0;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        default: begin
          if (prechEnd) begin
            state    <= ST_IDLE;
            phaseCnt <= '0;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
      endcase
    end
  end

  logic inLead, inStrobe;
  assign inLead   = (state == ST_LEAD);
  assign inStrobe = (state == ST_STROBE);

  always_comb begin
    strobe.rasLow    = inStrobe;
    strobe.cycleDone = (state == ST_PRECH) && prechEnd;
  end

  generate
    if (CBR_MODE != 0) begin : g_colFirst
      // column strobe leads, device counts rows itself
      always_comb begin
        strobe.casLow = inLead || inStrobe;
        strobe.addrEn = 1'b0;
      end
    end else begin : g_rowAddr
      // row address set up during lead, held while row strobe is low
      always_comb begin
        strobe.casLow = 1'b0;
        strobe.addrEn = inLead || inStrobe;
      end
    end
  endgenerate

endmodule

// File: rtl/refresh_dpath.sv
module refresh_dpath
  import refresh_pkg::*;
#(
  parameter int NUM_ROWS     = 8192,
  parameter int TIMER_PERIOD = 390,
  parameter int MISS_W       = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  rfshStrobe_t                 strobe,
  output logic                        pending,
  output logic                        rasN,
  output logic                        casN,
  output logic                        addrEn,
  output logic [$clog2(NUM_ROWS)-1:0] rowAddr,
  output logic [MISS_W-1:0]           missCount
);

  localparam int ROW_W = $clog2(NUM_ROWS);
  localparam int TMR_W = $clog2(TIMER_PERIOD);
  localparam logic [MISS_W-1:0] MISS_MAX = {MISS_W{1'b1}};

  logic [TMR_W-1:0] timerCnt;
  logic             expiry;
  logic [ROW_W-1:0] rowCnt;

  assign expiry = (timerCnt == TMR_W'(TIMER_PERIOD - 1));

  always_ff @(posedge clk) begin
    if (!rstN) timerCnt <= '0;
    else if (expiry) timerCnt <= '0;
    else timerCnt <= timerCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pending <= 1'b0;
    else pending <= expiry || (pending && !strobe.cycleDone);
  end

  always_ff @(posedge clk) begin
    if (!rstN) missCount <= '0;
    else if (expiry && pending && !strobe.cycleDone && (missCount != MISS_MAX))
      missCount <= missCount + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rowCnt <= '0;
    else if (strobe.cycleDone) begin
      if (rowCnt == ROW_W'(NUM_ROWS - 1)) rowCnt <= '0;
      else rowCnt <= rowCnt + 1'b1;
    end
  end

  assign rowAddr = rowCnt;
  assign rasN    = !strobe.rasLow;
  assign casN    = !strobe.casLow;
  assign addrEn  = strobe.addrEn;

endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler
  import refresh_pkg::*;
#(
  parameter int NUM_ROWS      = 8192,
  parameter int TIMER_PERIOD  = 390,
  parameter int RAS_LOW_CYC   = 3,
  parameter int PRECHARGE_CYC = 2,
  parameter int LEAD_CYC      = 1,
  parameter int CBR_MODE      = 0,
  parameter int MISS_W        = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        busGrant,
  output logic                        busReq,
  output logic                        rasN,
  output logic                        casN,
  output logic                        addrEn,
  output logic [$clog2(NUM_ROWS)-1:0] rowAddr,
  output logic [MISS_W-1:0]           missCount
);

  rfshStrobe_t strobe;
  logic pending;

  refresh_ctrl #(
    .CBR_MODE     (CBR_MODE),
    .LEAD_CYC     (LEAD_CYC),
    .RAS_LOW_CYC  (RAS_LOW_CYC),
    .PRECHARGE_CYC(PRECHARGE_CYC)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .pending (pending),
    .busGrant(busGrant),
    .strobe  (strobe)
  );

  refresh_dpath #(
    .NUM_ROWS    (NUM_ROWS),
    .TIMER_PERIOD(TIMER_PERIOD),
    .MISS_W      (MISS_W)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .pending  (pending),
    .rasN     (rasN),
    .casN     (casN),
    .addrEn   (addrEn),
    .rowAddr  (rowAddr),
    .missCount(missCount)
  );

  assign busReq = pending;

endmodule

// File: rtl/refresh_checker.sv
module refresh_checker #(
  parameter int NUM_ROWS      = 8192,
  parameter int RAS_LOW_CYC   = 3,
  parameter int PRECHARGE_CYC = 2,
  parameter int CBR_MODE      = 0,
  parameter int MISS_W        = 8
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        busGrant,
  input logic                        busReq,
  input logic                        rasN,
  input logic                        casN,
  input logic                        addrEn,
  input logic [$clog2(NUM_ROWS)-1:0] rowAddr,
  input logic [MISS_W-1:0]           missCount
);

  localparam int ROW_W = $clog2(NUM_ROWS);

  logic [7:0] lowRun, highRun;
  logic [ROW_W-1:0] expRow;
  logic addrEnQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowRun  <= '0;
      highRun <= '0;
      expRow  <= '0;
      addrEnQ <= 1'b0;
    end else begin
      lowRun  <= rasN ? 8'd0 : ((lowRun == 8'hff) ? lowRun : lowRun + 8'd1);
      highRun <= !rasN ? 8'd0 : ((highRun == 8'hff) ? highRun : highRun + 8'd1);
      addrEnQ <= addrEn;
      if (addrEnQ && !addrEn)
        expRow <= (expRow == ROW_W'(NUM_ROWS - 1)) ? '0 : expRow + 1'b1;
    end
  end

  p_strobe_in_req_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!rasN || !casN) |-> busReq);

  p_grant_first_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(addrEn) || $fell(casN)) |-> $past(busGrant));

  p_ras_width_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |-> (lowRun == 8'(RAS_LOW_CYC)));

  p_precharge_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busReq) |-> (rasN && highRun >= 8'(PRECHARGE_CYC)));

  p_miss_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    (missCount == $past(missCount)) || (missCount == $past(missCount) + 1'b1));

  generate
    if (CBR_MODE != 0) begin : g_colFirst
      p_cas_leads_r5: assert property (@(posedge clk) disable iff (!rstN)
        $fell(rasN) |-> (!casN && $past(!casN) && !addrEn));
    end else begin : g_rowAddr
      p_addr_setup_r4: assert property (@(posedge clk) disable iff (!rstN)
        $fell(rasN) |-> (addrEn && $past(addrEn) && casN));
      p_row_order_r8: assert property (@(posedge clk) disable iff (!rstN)
        addrEn |-> (rowAddr == expRow));
    end
  endgenerate

endmodule

bind refresh_scheduler refresh_checker #(
  .NUM_ROWS     (NUM_ROWS),
  .RAS_LOW_CYC  (RAS_LOW_CYC),
  .PRECHARGE_CYC(PRECHARGE_CYC),
  .CBR_MODE     (CBR_MODE),
  .MISS_W       (MISS_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busGrant (busGrant),
  .busReq   (busReq),
  .rasN     (rasN),
  .casN     (casN),
  .addrEn   (addrEn),
  .rowAddr  (rowAddr),
  .missCount(missCount)
);

// File: tb/sim_refresh_scheduler.sv
`timescale 1ns/1ps
module sim_refresh_scheduler;

  localparam int ROWS   = 4;
  localparam int PERIOD = 20;
  localparam int RASLOW = 3;
  localparam int PRECH  = 2;
  localparam int LEAD   = 1;
  localparam int NWALK  = 6;
  localparam int EXP_ROW [NWALK] = '{0, 1, 2, 3, 0, 1};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic grant0 = 1'b1, grant1 = 1'b1;
  logic req0, ras0, cas0, aen0, req1, ras1, cas1, aen1;
  logic [1:0] row0, row1;
  logic [3:0] miss0;
  logic [1:0] miss1;

  int nChecks = 0, nFail = 0, cyc = 0;
  bit done = 0, casSeen0 = 0, addrSeen1 = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  refresh_scheduler #(.NUM_ROWS(ROWS), .TIMER_PERIOD(PERIOD), .RAS_LOW_CYC(RASLOW),
    .PRECHARGE_CYC(PRECH), .LEAD_CYC(LEAD), .CBR_MODE(0), .MISS_W(4)) u0 (
    .clk(clk), .rstN(rstN), .busGrant(grant0), .busReq(req0), .rasN(ras0), .casN(cas0),
    .addrEn(aen0), .rowAddr(row0), .missCount(miss0));

  refresh_scheduler #(.NUM_ROWS(ROWS), .TIMER_PERIOD(PERIOD), .RAS_LOW_CYC(RASLOW),
    .PRECHARGE_CYC(PRECH), .LEAD_CYC(LEAD), .CBR_MODE(1), .MISS_W(2)) u1 (
    .clk(clk), .rstN(rstN), .busGrant(grant1), .busReq(req1), .rasN(ras1), .casN(cas1),
    .addrEn(aen1), .rowAddr(row1), .missCount(miss1));

  always @(negedge clk) if (rstN) begin
    if (!cas0) casSeen0 = 1;
    if (aen1) addrSeen1 = 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    int lastFall, nLow, nPre, prevAen, n;
    lastFall = 0;
    repeat (3) @(negedge clk);
    chk("R1 rasN", ras0, 1);     chk("R1 casN", cas0, 1);
    chk("R1 busReq", req0, 0);   chk("R1 addrEn", aen0, 0);
    chk("R1 missCount", miss0, 0);
    chk("R1 cbr rasN", ras1, 1); chk("R1 cbr casN", cas1, 1);
    rstN = 1'b1;

    // table walk: row-address-only refreshes with grant always given
    for (int i = 0; i < NWALK; i++) begin
      prevAen = 0;
      @(negedge clk);
      while (ras0) begin prevAen = aen0; @(negedge clk); end
      chk("R8 row order", row0, EXP_ROW[i]);
      chk("R4 addr before strobe", prevAen, 1);
      chk("R4 addr during strobe", aen0, 1);
      if (i > 0) chk("R2 refresh spacing", cyc - lastFall, PERIOD);
      lastFall = cyc;
      nLow = 0;
      while (!ras0) begin nLow++; @(negedge clk); end
      chk("R6 row strobe width", nLow, RASLOW);
      nPre = 0;
      while (req0 && ras0) begin nPre++; @(negedge clk); end
      chk("R7 precharge before release", nPre, PRECH);
      chk("R7 request released", req0, 0);
    end
    chk("R9 no miss with prompt grant", miss0, 0);
    chk("R4 column strobe idle", casSeen0, 0);

    // starved grant: one refresh ends, grant withheld across two expiries
    @(negedge clk);
    while (!req0) @(negedge clk);
    while (req0) @(negedge clk);
    grant0 = 1'b0;
    n = 0;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      if (!ras0 || !cas0 || aen0) n++;
    end
    chk("R3 no strobe without grant", n, 0);
    chk("R3 request held", req0, 1);
    chk("R9 one missed refresh", miss0, 1);
    grant0 = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (ras0);
    chk("R3 strobe after grant", n, 2);
    chk("R8 row wraps and continues", row0, 3);
    chk("R9 miss held", miss0, 1);

    // column-before-row style
    @(negedge clk);
    while (cas1) @(negedge clk);
    chk("R5 column strobe first", ras1, 1);
    n = 0;
    while (!cas1 && ras1) begin n++; @(negedge clk); end
    chk("R5 lead cycles", n, LEAD);
    nLow = 0;
    while (!ras1 && !cas1) begin nLow++; @(negedge clk); end
    chk("R6 cbr strobe width", nLow, RASLOW);
    chk("R5 column rises with row", {ras1, cas1}, 3);
    chk("R5 no address driven", addrSeen1, 0);

    // saturation of a 2-bit miss counter
    @(negedge clk);
    while (req1) @(negedge clk);
    grant1 = 1'b0;
    repeat (200) @(negedge clk);
    chk("R9 miss saturates", miss1, 3);

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule